// File: doc/BRIEF.md
# Frame Clock Ratio Error Detector

This block watches the serial audio bit clock and frame clock, both sampled by the master clock. It decides, frame by frame, whether the two clocks agree with the configured sample format. At every frame-clock rising edge it counts the bit-clock rising edges seen since the previous frame edge. That count must equal the number of slots times the slot width. The frame period, counted in master-clock cycles, must also fall inside a programmable window.

One bad frame is tolerated, so a glitch during a format change is filtered out. A second bad frame in a row raises a sticky clock-error flag. The same flag drives the amplifier shutdown output. To release the flag, pulse the clear input and then let one good frame pass. A frame clock that stops altogether is caught by a timeout tied to the upper period limit.

Top module: `fcr_monitor`

## Requirements
- R1: While reset is high, and on the first cycle after it, the clock-error and shutdown outputs are low.
- R2: The expected bit count per frame is slots × slot width. The slot-count code is 00 for 2, 01 for 4, and 10 or 11 for 8. The slot-width code is 00 for 16, 01 for 24, and 10 or 11 for 32. A frame that meets both the count and the period window is good.
- R3: A frame is bad when the number of bit-clock rising edges between two frame-clock rising edges differs from the expected count. A bit-clock rise that falls in the same master cycle as a frame rise belongs to the frame that is ending.
- R4: A frame is bad when its period is below the minimum limit or above the maximum limit. The period is the number of master-clock cycles between consecutive frame-clock rises.
- R5: The clock-error flag sets on the second of two consecutive bad frames, in the master cycle after that frame's closing edge is sampled. A single bad frame followed by a good one leaves the flag low.
- R6: The shutdown output equals the clock-error flag on every cycle.
- R7: The error flag is sticky. It falls only on the first good frame that ends after a clear pulse given while the flag was high. A clear pulse given while the flag is low has no effect.
- R8: When the period counter reaches the maximum limit without a frame rise, that counts as a bad frame, and measurement restarts.
- R9: No frame is judged until the first frame-clock rise after reset. Edges are not detected on the first cycle after reset, and no timeout can occur before that first rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Bit clock level, synchronous to clk |
| fclk_i | input | 1 | Frame clock level, synchronous to clk |
| slot_cnt_sel | input | 2 | Slot-count code |
| slot_w_sel | input | 2 | Slot-width code |
| per_min | input | PER_W | Minimum frame period in master cycles |
| per_max | input | PER_W | Maximum frame period in master cycles |
| clr_i | input | 1 | Clear request pulse |
| clk_err_o | output | 1 | Sticky clock-error flag |
| amp_sd_o | output | 1 | Amplifier shutdown |

## Verification
The assertions take for granted that both audio clocks already arrive synchronous to the master clock. They also assume each level is held for at least one master cycle, and that the limits satisfy per_min ≤ per_max and change only while the monitor is being settled. The stimulus builds both audio clocks from counters in the master domain. The frame clock changes only on bit-clock falling edges. Every change of format or period is followed by a settling interval and a clear before anything is expected of the flag.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    typedef enum logic [1:0] {
        SLOTS_2     = 2'b00,
        SLOTS_4     = 2'b01,
        SLOTS_8     = 2'b10,
        SLOTS_8_ALT = 2'b11
    } slot_cnt_e;

    typedef enum logic [1:0] {
        SW_16     = 2'b00,
        SW_24     = 2'b01,
        SW_32     = 2'b10,
        SW_32_ALT = 2'b11
    } slot_w_e;

    typedef struct packed {
        logic valid;
        logic bad;
    } verdict_t;

    function automatic int unsigned slots_of(slot_cnt_e c);
        case (c)
            SLOTS_2: return 2;
            SLOTS_4: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic int unsigned width_of(slot_w_e w);
        case (w)
            SW_16:   return 16;
            SW_24:   return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/fcr_edge.sv
module fcr_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic         vld;
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            prev <= '0;
        end else begin
            vld  <= 1'b1;
            prev <= lvl;
        end
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_rise
        assign rise[gi] = vld & lvl[gi] & ~prev[gi];
    end
endmodule

// File: rtl/fcr_meas.sv
module fcr_meas
    import fcr_pkg::*;
#(
    parameter int BCNT_W = 10,
    parameter int PER_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk_rise,
    input  logic              fclk_rise,
    input  logic [BCNT_W-1:0] exp_bits,
    input  logic [PER_W-1:0]  per_min,
    input  logic [PER_W-1:0]  per_max,
    output verdict_t          verdict,
    output logic              started_o
);
    localparam logic [BCNT_W-1:0] BSAT = '1;

    logic              started;
    logic [BCNT_W-1:0] bcnt, bsum;
    logic [PER_W-1:0]  pcnt;
    logic [PER_W:0]    period;
    logic              timeout, count_bad, per_bad;

    always_comb begin
        bsum      = (bcnt == BSAT) ? bcnt : bcnt + BCNT_W'(bclk_rise);
        period    = {1'b0, pcnt} + {{PER_W{1'b0}}, 1'b1};
        count_bad = (bsum != exp_bits);
        per_bad   = (period < {1'b0, per_min}) || (period > {1'b0, per_max});
        timeout   = started && !fclk_rise && (pcnt >= per_max);
        verdict.valid = (started && fclk_rise) || timeout;
        verdict.bad   = timeout || count_bad || per_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            started <= 1'b0;
            bcnt    <= '0;
            pcnt    <= '0;
        end else if (fclk_rise || timeout) begin
            started <= 1'b1;
            bcnt    <= '0;
            pcnt    <= '0;
        end else begin
            bcnt    <= bsum;
            pcnt    <= pcnt + 1'b1;
        end
    end

    assign started_o = started;
endmodule

// File: rtl/fcr_latch.sv
module fcr_latch
    import fcr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t verdict,
    input  logic     clr,
    output logic     err_o,
    output logic     pend_o
);
    logic err, pend, streak;
    logic err_n, pend_n, streak_n;

    always_comb begin
        err_n    = err;
        pend_n   = pend;
        streak_n = streak;
        if (verdict.valid) begin
            if (verdict.bad) begin
                streak_n = 1'b1;
                if (streak) err_n = 1'b1;
            end else begin
                streak_n = 1'b0;
                if (pend) begin
                    err_n  = 1'b0;
                    pend_n = 1'b0;
                end
            end
        end
        if (clr && err && err_n) pend_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err    <= 1'b0;
            pend   <= 1'b0;
            streak <= 1'b0;
        end else begin
            err    <= err_n;
            pend   <= pend_n;
            streak <= streak_n;
        end
    end

    assign err_o  = err;
    assign pend_o = pend;
endmodule

// File: rtl/fcr_monitor.sv
module fcr_monitor
    import fcr_pkg::*;
#(
    parameter int MAX_SLOTS     = 8,
    parameter int MAX_SLOT_BITS = 32,
    parameter int PER_W         = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk_i,
    input  logic             fclk_i,
    input  logic [1:0]       slot_cnt_sel,
    input  logic [1:0]       slot_w_sel,
    input  logic [PER_W-1:0] per_min,
    input  logic [PER_W-1:0] per_max,
    input  logic             clr_i,
    output logic             clk_err_o,
    output logic             amp_sd_o
);
    localparam int BITS_MAX = MAX_SLOTS * MAX_SLOT_BITS;
    localparam int BCNT_W   = $clog2(BITS_MAX + 1) + 1;

    logic [1:0]        rise;
    logic              bclk_rise, fclk_rise;
    logic [BCNT_W-1:0] exp_bits;
    verdict_t          verdict;
    logic              started, pend;
    logic              frm_valid, frm_bad;

    assign exp_bits = BCNT_W'(slots_of(slot_cnt_e'(slot_cnt_sel))
                             * width_of(slot_w_e'(slot_w_sel)));

    fcr_edge #(.N(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({fclk_i, bclk_i}),
        .rise (rise)
    );

    assign bclk_rise = rise[0];
    assign fclk_rise = rise[1];

    fcr_meas #(.BCNT_W(BCNT_W), .PER_W(PER_W)) u_meas (
        .clk       (clk),
        .rst       (rst),
        .bclk_rise (bclk_rise),
        .fclk_rise (fclk_rise),
        .exp_bits  (exp_bits),
        .per_min   (per_min),
        .per_max   (per_max),
        .verdict   (verdict),
        .started_o (started)
    );

    fcr_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .verdict (verdict),
        .clr     (clr_i),
        .err_o   (clk_err_o),
        .pend_o  (pend)
    );

    assign frm_valid = verdict.valid;
    assign frm_bad   = verdict.bad;
    assign amp_sd_o  = clk_err_o;
endmodule

// File: rtl/fcr_monitor_chk.sv
module fcr_monitor_chk (
    input logic clk,
    input logic rst,
    input logic clk_err_o,
    input logic amp_sd_o,
    input logic fclk_rise,
    input logic frm_valid,
    input logic frm_bad,
    input logic pend,
    input logic started
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!clk_err_o && !amp_sd_o));

    assert_err_rise_on_bad_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_err_o) |-> $past(frm_valid && frm_bad));

    assert_release_after_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_err_o) |-> $past(pend && frm_valid && !frm_bad));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (clk_err_o && !pend) |=> clk_err_o);

    assert_pend_with_err_R7: assert property (@(posedge clk) disable iff (rst)
        pend |-> clk_err_o);

    assert_timeout_bad_R8: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !fclk_rise) |-> frm_bad);

    assert_no_verdict_early_R9: assert property (@(posedge clk) disable iff (rst)
        !started |-> !frm_valid);
endmodule

bind fcr_monitor fcr_monitor_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_err_o (clk_err_o),
    .amp_sd_o  (amp_sd_o),
    .fclk_rise (fclk_rise),
    .frm_valid (frm_valid),
    .frm_bad   (frm_bad),
    .pend      (pend),
    .started   (started)
);

// File: tb/test_fcr_monitor.sv
`timescale 1ns/1ps
module test_fcr_monitor;
    localparam int PER_W = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst  = 1'b1;
    logic             bclk = 1'b0;
    logic             fclk = 1'b0;
    logic             clr  = 1'b0;
    logic [1:0]       scnt = 2'b00;
    logic [1:0]       swid = 2'b10;
    logic [PER_W-1:0] pmin = 16'd200;
    logic [PER_W-1:0] pmax = 16'd300;
    logic             err, sd;

    fcr_monitor #(.PER_W(PER_W)) i_fcr_monitor (
        .clk          (clk),
        .rst          (rst),
        .bclk_i       (bclk),
        .fclk_i       (fclk),
        .slot_cnt_sel (scnt),
        .slot_w_sel   (swid),
        .per_min      (pmin),
        .per_max      (pmax),
        .clr_i        (clr),
        .clk_err_o    (err),
        .amp_sd_o     (sd)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // stimulus generator controls
    int ph = 0, bi = 0, cur_len = 64, cur_half = 2;
    int good_len = 64, bad_len = 62, bad_left = 0, half_req = 2;
    bit gen_on = 1, fstop = 0;
    int clr_req = 0;

    // reference model state
    bit m_pv = 0, m_pb = 0, m_pf = 0, m_started = 0, m_streak = 0, m_err = 0, m_pend = 0;
    int m_bc = 0, m_pc = 0;

    function automatic int exp_bits();
        int s, w;
        s = (scnt == 2'b00) ? 2 : (scnt == 2'b01) ? 4 : 8;
        w = (swid == 2'b00) ? 16 : (swid == 2'b01) ? 24 : 32;
        return s * w;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    always @(negedge clk) begin : model_gen
        bit br, fr, fv, fb, e_old;
        int per;
        if (rst) begin
            m_pv = 0; m_pb = 0; m_pf = 0; m_started = 0;
            m_streak = 0; m_err = 0; m_pend = 0; m_bc = 0; m_pc = 0;
        end else begin
            br = 0; fr = 0;
            if (m_pv) begin
                br = bclk && !m_pb;
                fr = fclk && !m_pf;
            end
            m_pv = 1; m_pb = bclk; m_pf = fclk;
            fv = 0; fb = 0;
            if (m_started && fr) begin
                fv  = 1;
                per = m_pc + 1;
                fb  = ((m_bc + int'(br)) != exp_bits()) || (per < int'(pmin)) || (per > int'(pmax));
                m_bc = 0; m_pc = 0;
            end else if (m_started && m_pc >= int'(pmax)) begin
                fv = 1; fb = 1; m_bc = 0; m_pc = 0;
            end else if (fr) begin
                m_started = 1; m_bc = 0; m_pc = 0;
            end else begin
                m_bc += int'(br);
                m_pc++;
            end
            e_old = m_err;
            if (fv) begin
                if (fb) begin
                    if (m_streak) m_err = 1;
                    m_streak = 1;
                end else begin
                    m_streak = 0;
                    if (m_pend) begin m_err = 0; m_pend = 0; end
                end
            end
            if (clr && e_old && m_err) m_pend = 1;
            chk("R5 model err", int'(err), int'(m_err));
            chk("R6 model shutdown", int'(sd), int'(m_err));
        end
        // drive the clear pulse
        clr = (clr_req != 0);
        clr_req = 0;
        // clock generator
        if (gen_on) begin
            ph++;
            if (ph == 2 * cur_half) begin
                ph = 0;
                bi++;
                if (bi >= cur_len) begin
                    bi = 0;
                    if (bad_left > 0) begin cur_len = bad_len; bad_left--; end
                    else cur_len = good_len;
                    cur_half = half_req;
                end
            end
            bclk = (ph >= cur_half);
            fclk = fstop ? 1'b0 : (bi < cur_len / 2);
        end
    end

    initial begin
        rst = 1;
        step(5);
        chk("R1 reset err", int'(err), 0);
        chk("R1 reset shutdown", int'(sd), 0);
        rst = 0;
        step(5 * 256);
        chk("R2 R9 good stream 2x32", int'(err), 0);

        bad_len = 62; bad_left = 1;
        step(5 * 256);
        chk("R5 single bad frame filtered", int'(err), 0);

        bad_left = 2;
        step(5 * 256);
        chk("R3 R5 two short frames", int'(err), 1);
        chk("R6 shutdown on error", int'(sd), 1);
        step(3 * 256);
        chk("R7 sticky without clear", int'(err), 1);
        clr_req = 1;
        step(3 * 256);
        chk("R7 clear then good frame", int'(err), 0);

        clr_req = 1;
        step(4);
        bad_left = 2;
        step(5 * 256);
        chk("R7 clear while low ignored", int'(err), 1);
        clr_req = 1;
        step(3 * 256);
        chk("R7 released", int'(err), 0);

        half_req = 3;
        step(4 * 384);
        chk("R4 period above max", int'(err), 1);
        half_req = 2;
        step(2 * 384);
        clr_req = 1;
        step(3 * 256);
        chk("R4 recovered", int'(err), 0);

        half_req = 1;
        step(4 * 256);
        chk("R4 period below min", int'(err), 1);
        half_req = 2;
        step(2 * 256);
        clr_req = 1;
        step(3 * 256);
        chk("R4 recovered short", int'(err), 0);

        scnt = 2'b01; swid = 2'b00;
        step(5 * 256);
        chk("R2 4x16 accepted", int'(err), 0);

        scnt = 2'b10; swid = 2'b01; pmin = 300; pmax = 500;
        good_len = 192; half_req = 1;
        step(2 * 512);
        clr_req = 1;
        step(3 * 384);
        chk("R2 8x24 accepted", int'(err), 0);

        scnt = 2'b11; swid = 2'b11; pmin = 400; pmax = 600;
        good_len = 256;
        step(2 * 512);
        clr_req = 1;
        step(3 * 512);
        chk("R2 code 11/11 gives 256", int'(err), 0);

        fstop = 1;
        step(2000);
        chk("R8 frame clock stopped", int'(err), 1);
        fstop = 0;
        step(2 * 512);
        clr_req = 1;
        step(3 * 512);
        chk("R8 recovered", int'(err), 0);

        rst = 1; gen_on = 0;
        step(3);
        rst = 0;
        step(2000);
        chk("R9 no timeout before first frame", int'(err), 0);
        gen_on = 1;
        step(4 * 512);
        chk("R9 partial first frame ignored", int'(err), 0);

        step(137);
        rst = 1;
        step(3);
        rst = 0;
        step(4 * 512);
        chk("R9 reset mid frame", int'(err), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R5 act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule